// File: doc/BRIEF.md
# Half-Contrast Pixel Switch

This block decides, for every pixel clock, whether the video picture is shown at full contrast, at reduced contrast, or replaced by pixels from an external RGB source. The reduced-contrast request arrives on a fast-switching pad input. Such a signal typically outlines a box behind on-screen text, so that the text stays readable over a bright picture.

The pad is shared with bit 0 of a general-purpose port. A select bit hands the pin to the half-contrast function, and the port driver then lets go of the pad. The pad level is first synchronized to the pixel clock. A force-high bit and a polarity bit then shape it into an internal half-contrast flag. The internal fast-blank signal overrides everything else. While it is asserted, the pixel comes from the external RGB path, and those pixels are never dimmed.

The contrast arithmetic is outside this block, and so is any analog path. The block hands a two-bit select code to the pixel datapath.

Top module: `hcs_switch`

## Requirements
- R1: While reset is asserted, and at the first sample after it is released, `hc_active` is 0 and `pix_sel` is 2'b00 (full video).
- R2: The pad input passes through SYNC_STAGES flip-flops and then the output register. A pad change that is set up before a rising edge reaches `hc_active` at the (SYNC_STAGES+1)-th rising edge, and not earlier.
- R3: When `fblank` is 1 at a rising edge, `pix_sel` becomes 2'b10 (external RGB) at that edge, whatever the half-contrast state is.
- R4: The internal half-contrast level is (`hc_force` OR synchronized pad) XOR `hc_pol`. `hc_active` shows that level one rising edge after `hc_force` or `hc_pol` is sampled.
- R5: With `fblank` low, `pix_sel` is 2'b01 (half-contrast video) when the level is 1 and 2'b00 when it is 0. The code 2'b11 never appears.
- R6: When `hc_sel` is 1, `pad_oe` is 0 whatever `port_dir` and `port_dat` are, so port writes do not reach the pin. When `hc_sel` is 0, `pad_oe` follows `port_dir` and `pad_out` follows `port_dat`.
- R7: With `hc_force`=1 and `hc_pol`=1, `hc_active` stays 0 for any pad level. This is the setting that holds the function off while the port owns the pin.
- R8: With `hc_force`=0 and `hc_pol`=1, a low pad level makes `hc_active` 1 and a high pad level makes it 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hcs_pad_i | input | 1 | Level read from the shared pad |
| hc_sel | input | 1 | 1: pin belongs to the half-contrast function; 0: pin is port bit 0 |
| hc_force | input | 1 | Forces the pre-polarity half-contrast level high |
| hc_pol | input | 1 | Inverts the half-contrast level |
| fblank | input | 1 | Internal fast-blank; 1 selects external RGB |
| port_dir | input | 1 | Port bit 0 direction, 1 = output |
| port_dat | input | 1 | Port bit 0 output data |
| pad_oe | output | 1 | Pad output enable |
| pad_out | output | 1 | Pad output data |
| hc_active | output | 1 | Registered internal half-contrast flag |
| pix_sel | output | 2 | 00 full video, 01 half-contrast video, 10 external RGB |

## Verification
The clocked properties take it for granted that `hc_force`, `hc_pol` and `fblank` are already synchronous to the pixel clock. They also assume each of these holds for a whole cycle around the edge that samples it. Only the pad input is treated as asynchronous. The bench therefore changes all inputs on the falling edge, including the pad, so every value is stable at the next rising edge. The pad is held long enough for the synchronizer to settle before any output is compared.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
   typedef enum logic [1:0] {
      PIX_FULL = 2'b00,
      PIX_HALF = 2'b01,
      PIX_EXT  = 2'b10
   } hcs_pix_e;

   localparam int PIX_SEL_W = $bits(hcs_pix_e);
   localparam int SYNC_MIN  = 2;
   localparam int SYNC_MAX  = 8;
endpackage

// File: rtl/hcs_sync.sv
module hcs_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= RST_VAL;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hcs_level.sv
module hcs_level (
   input  logic pad_sync,
   input  logic force_hi,
   input  logic invert,
   output logic level
);
   logic pre_pol;

   always_comb begin
      pre_pol = force_hi | pad_sync;
      level   = pre_pol ^ invert;
   end
endmodule

// File: rtl/hcs_pix_mux.sv
module hcs_pix_mux
   import hcs_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 level,
   input  logic                 ext_rgb,
   output logic                 flag_q,
   output logic [PIX_SEL_W-1:0] sel_q
);
   hcs_pix_e sel_d;

   always_comb begin
      if (ext_rgb)    sel_d = PIX_EXT;
      else if (level) sel_d = PIX_HALF;
      else            sel_d = PIX_FULL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         sel_q  <= PIX_FULL;
      end else begin
         flag_q <= level;
         sel_q  <= sel_d;
      end
   end
endmodule

// File: rtl/hcs_pin_share.sv
module hcs_pin_share (
   input  logic func_owns,
   input  logic dir_out,
   input  logic dat,
   output logic oe,
   output logic dout
);
   always_comb begin
      oe   = dir_out & ~func_owns;
      dout = func_owns ? 1'b0 : dat;
   end
endmodule

// File: rtl/hcs_switch.sv
module hcs_switch
   import hcs_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit PAD_RST_VAL = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hcs_pad_i,
   input  logic                 hc_sel,
   input  logic                 hc_force,
   input  logic                 hc_pol,
   input  logic                 fblank,
   input  logic                 port_dir,
   input  logic                 port_dat,
   output logic                 pad_oe,
   output logic                 pad_out,
   output logic                 hc_active,
   output logic [PIX_SEL_W-1:0] pix_sel
);
   generate
      if (SYNC_STAGES < SYNC_MIN || SYNC_STAGES > SYNC_MAX) begin : g_bad_sync
         $error("hcs_switch: SYNC_STAGES out of range");
      end
   endgenerate

   logic pad_s;
   logic hc_lvl;

   hcs_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PAD_RST_VAL)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (hcs_pad_i),
      .q     (pad_s)
   );

   hcs_level u_level (
      .pad_sync (pad_s),
      .force_hi (hc_force),
      .invert   (hc_pol),
      .level    (hc_lvl)
   );

   hcs_pix_mux u_mux (
      .clk     (clk),
      .rst_n   (rst_n),
      .level   (hc_lvl),
      .ext_rgb (fblank),
      .flag_q  (hc_active),
      .sel_q   (pix_sel)
   );

   hcs_pin_share u_pin (
      .func_owns (hc_sel),
      .dir_out   (port_dir),
      .dat       (port_dat),
      .oe        (pad_oe),
      .dout      (pad_out)
   );
endmodule

// File: rtl/hcs_switch_chk.sv
module hcs_switch_chk
   import hcs_pkg::*;
(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 hc_sel,
   input logic                 hc_force,
   input logic                 hc_pol,
   input logic                 fblank,
   input logic                 port_dir,
   input logic                 port_dat,
   input logic                 pad_oe,
   input logic                 pad_out,
   input logic                 hc_active,
   input logic [PIX_SEL_W-1:0] pix_sel
);
   // R3: fast-blank wins over everything on the next edge
   a_r3_ext_priority: assert property (@(posedge clk) disable iff (!rst_n)
      fblank |=> (pix_sel == PIX_EXT));

   // R5: the unused code never leaves the register
   a_r5_no_code3: assert property (@(posedge clk) disable iff (!rst_n)
      pix_sel != 2'b11);

   // R4: forced level without inversion gives half contrast
   a_r4_forced_on: assert property (@(posedge clk) disable iff (!rst_n)
      (hc_force && !hc_pol && !fblank) |=> (hc_active && pix_sel == PIX_HALF));

   // R7: force plus inversion keeps the function off
   a_r7_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
      (hc_force && hc_pol && !fblank) |=> (!hc_active && pix_sel == PIX_FULL));

   // R6: the pin is released while the function owns it
   a_r6_pin_released: assert property (@(posedge clk) disable iff (!rst_n)
      hc_sel |-> !pad_oe);

   // R6: the port drives the pin when it owns it
   a_r6_port_drives: assert property (@(posedge clk) disable iff (!rst_n)
      !hc_sel |-> (pad_oe == port_dir && pad_out == port_dat));
endmodule

bind hcs_switch hcs_switch_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hc_sel    (hc_sel),
   .hc_force  (hc_force),
   .hc_pol    (hc_pol),
   .fblank    (fblank),
   .port_dir  (port_dir),
   .port_dat  (port_dat),
   .pad_oe    (pad_oe),
   .pad_out   (pad_out),
   .hc_active (hc_active),
   .pix_sel   (pix_sel)
);

// File: tb/hcs_switch_bench.sv
module hcs_switch_bench;
   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       hcs_pad_i = 1'b0;
   logic       hc_sel = 1'b0;
   logic       hc_force = 1'b0;
   logic       hc_pol = 1'b0;
   logic       fblank = 1'b0;
   logic       port_dir = 1'b0;
   logic       port_dat = 1'b0;
   logic       pad_oe, pad_out, hc_active;
   logic [1:0] pix_sel;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   hcs_switch #(.SYNC_STAGES(SYNC)) u_hcs_switch (
      .clk(clk), .rst_n(rst_n), .hcs_pad_i(hcs_pad_i), .hc_sel(hc_sel),
      .hc_force(hc_force), .hc_pol(hc_pol), .fblank(fblank),
      .port_dir(port_dir), .port_dat(port_dat), .pad_oe(pad_oe),
      .pad_out(pad_out), .hc_active(hc_active), .pix_sel(pix_sel)
   );

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #2 rst_n = 1'b0;
      hcs_pad_i = 1'b1;
      hc_force  = 1'b1;
      fblank    = 1'b1;
      wait_neg(3);
      check("R1 flag in reset", int'(hc_active), 0);
      check("R1 sel in reset", int'(pix_sel), 0);
      hcs_pad_i = 1'b0; hc_force = 1'b0; fblank = 1'b0;
      rst_n = 1'b1;
      wait_neg(1);
      check("R1 flag after reset", int'(hc_active), 0);
      check("R1 sel after reset", int'(pix_sel), 0);

      // R2 latency of the pad path
      wait_neg(SYNC + 2);
      hcs_pad_i = 1'b1;
      wait_neg(SYNC);
      check("R2 not yet visible", int'(hc_active), 0);
      wait_neg(1);
      check("R2 visible", int'(hc_active), 1);
      hcs_pad_i = 1'b0;
      wait_neg(SYNC);
      check("R2 fall not yet visible", int'(hc_active), 1);
      wait_neg(1);
      check("R2 fall visible", int'(hc_active), 0);

      // R4 register input latency is one edge
      hc_force = 1'b1;
      wait_neg(1);
      check("R4 force one edge", int'(hc_active), 1);
      hc_force = 1'b0;
      wait_neg(1);

      // sweep force, pol, fblank, pad: R3 R4 R5 R7 R8
      for (int v = 0; v < 16; v++) begin
         bit f, p, fb, pd, lvl;
         int exp_sel;
         f = v[0]; p = v[1]; fb = v[2]; pd = v[3];
         hc_sel = 1'b1;
         hc_force = f; hc_pol = p; fblank = fb; hcs_pad_i = pd;
         wait_neg(SYNC + 2);
         lvl = (f | pd) ^ p;
         exp_sel = fb ? 2 : (lvl ? 1 : 0);
         check(fb ? "R3 ext priority" : "R5 pix select", int'(pix_sel), exp_sel);
         if (f && p)
            check("R7 held off", int'(hc_active), 0);
         else if (!f && p)
            check("R8 inverted level", int'(hc_active), int'(!pd));
         else
            check("R4 level", int'(hc_active), int'(lvl));
      end

      // R6 pin sharing sweep
      for (int v = 0; v < 8; v++) begin
         hc_sel = v[0]; port_dir = v[1]; port_dat = v[2];
         wait_neg(1);
         if (v[0]) begin
            check("R6 pin released", int'(pad_oe), 0);
         end else begin
            check("R6 port oe", int'(pad_oe), int'(v[1]));
            check("R6 port data", int'(pad_out), int'(v[2]));
         end
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule